// File: doc/BRIEF.md
# Event Status and Interrupt Register Block

This block collects the event flags of a memory-card host controller and raises one level interrupt. The command, data and FIFO engines each report an event as a single-cycle pulse. The block latches every pulse into a sticky status bit, and the bit stays set until software writes a one to the matching position of the clear register. A mask register selects which sticky bits drive the interrupt output.

Two asynchronous pin levels also enter the block: card-absent and write-protect. Each passes through a synchroniser and is shown live in the status word. Neither can be cleared. Any change of the synchronised card-absent level raises the card-change event internally. The register interface is a single-cycle write strobe with a word address, plus a combinational read port on the same address.

Top module: `evst_irq_regs`

## Requirements
- R1: After a synchronous active-low reset, all eleven event bits and all mask bits read 0. The interrupt output is low. The status word reads 0x0800, because the card-absent level resets to 1 and the write-protect level resets to 0.
- R2: A one-cycle pulse on `evt_in[i]` (i from 0 to 9) sets status bit i at the next clock edge. The bit stays set through later idle cycles.
- R3: A write to address 1 (clear) with data bit i at 1 clears status bit i (i from 0 to 10) at that edge. Bits written with 0 keep their value.
- R4: When a set pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: Address 2 is the mask register. Bits 0 to 10 can be written and read back. All other bits of the mask word read 0.
- R6: `irq` is high exactly while at least one status bit from 0 to 10 and the matching mask bit are both 1. It follows the registered state in the same cycle, with no extra delay.
- R7: Status bit 11 shows the card-absent pin level and bit 12 shows the write-protect pin level. Each passes through a two-stage synchroniser, so a pin change reaches the status word two clock edges later.
- R8: A rising or a falling change of the synchronised card-absent level sets status bit 10 (card change) at the following clock edge.
- R9: Writes to address 0 (status) have no effect. Clear-register bits 11 and 12 have no effect. Address 1 and address 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 10 | Single-cycle event pulses, bit positions 0 to 9 |
| card_absent_pin | input | 1 | Asynchronous card-absent level (1 means no card) |
| wprot_pin | input | 1 | Asynchronous write-protect level |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 clear, 2 mask, 3 unused |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt |

## Verification
A wrong sticky bit, mask bit or edge-detector state shows up on the status or mask read one edge after the stimulus that caused it. If the bit is masked in, it also shows on `irq` in that same cycle. A synchroniser of the wrong depth moves bits 11, 12 and 10 by whole cycles. A lost card-change shows up as a missing bit 10 exactly three edges after the pin moves. A behavioural model advanced on every edge is compared against the read port and the interrupt on every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/evst_pkg.sv
// Shared constants for the event status block: bit positions and the address map.
package evst_pkg;
    localparam int NUM_EVT   = 11;           // sticky event bits 0..10
    localparam int NUM_EXT   = NUM_EVT - 1;  // externally pulsed events 0..9
    localparam int CHG_BIT   = 10;           // card change, generated inside
    localparam int CD_BIT    = 11;           // live card-absent level
    localparam int WP_BIT    = 12;           // live write-protect level
    localparam int ADDR_W    = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_STATUS = 2'd0,
        A_CLEAR  = 2'd1,
        A_MASK   = 2'd2,
        A_SPARE  = 2'd3
    } evst_addr_e;
endpackage

// File: rtl/evst_sync.sv
// Multi-stage level synchroniser.
// Assumes: STAGES >= 2; input is a slow level, not a pulse.
module evst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the pin level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/evst_edge.sv
// Detects either edge of a synchronised level as a one-cycle pulse.
// Assumes: RST_VAL matches the reset value of the synchroniser feeding it,
// so reset itself gives no false edge.
module evst_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic chg
);
    logic prev_q;

    // remember the level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    assign chg = lvl ^ prev_q;
endmodule

// File: rtl/evst_sticky.sv
// Bank of sticky flags: set by pulse, cleared by write-one, set has priority.
// Assumes: set and clr are sampled on the same edge.
module evst_sticky #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // hold one flag; a set in the same cycle overrides a clear
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/evst_irq_regs.sv
// Event status, write-one-to-clear and mask registers with one level interrupt.
// Assumes: evt_in bits are single-cycle pulses in the clk domain; the pins
// are asynchronous levels; REG_W is at least WP_BIT+1.
module evst_irq_regs
    import evst_pkg::*;
#(
    parameter int REG_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [9:0]        evt_in,
    input  logic              card_absent_pin,
    input  logic              wprot_pin,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    logic               cd_s, wp_s, cd_chg;
    logic [NUM_EVT-1:0] set_vec, clr_vec, st_q, mask_q;
    logic               wr_clr, wr_mask;

    evst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cd_sync (
        .clk(clk), .rst_n(rst_n), .d(card_absent_pin), .q(cd_s));

    evst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_wp_sync (
        .clk(clk), .rst_n(rst_n), .d(wprot_pin), .q(wp_s));

    evst_edge #(.RST_VAL(1'b1)) u_cd_edge (
        .clk(clk), .rst_n(rst_n), .lvl(cd_s), .chg(cd_chg));

    // decode which register a write targets
    always_comb begin
        wr_clr  = reg_wr_en && (evst_addr_e'(reg_addr) == A_CLEAR);
        wr_mask = reg_wr_en && (evst_addr_e'(reg_addr) == A_MASK);
    end

    assign set_vec = {cd_chg, evt_in[NUM_EXT-1:0]};
    assign clr_vec = wr_clr ? reg_wdata[NUM_EVT-1:0] : '0;

    evst_sticky #(.N(NUM_EVT)) u_sticky (
        .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(clr_vec), .q(st_q));

    // mask register, written whole
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= reg_wdata[NUM_EVT-1:0];
    end

    // read mux over the address map
    always_comb begin
        reg_rdata = '0;
        unique case (evst_addr_e'(reg_addr))
            A_STATUS: begin
                reg_rdata[NUM_EVT-1:0] = st_q;
                reg_rdata[CD_BIT]      = cd_s;
                reg_rdata[WP_BIT]      = wp_s;
            end
            A_MASK:   reg_rdata[NUM_EVT-1:0] = mask_q;
            default:  reg_rdata = '0;
        endcase
    end

    // interrupt is the OR of unmasked sticky flags
    assign irq = |(st_q & mask_q);
endmodule

// File: rtl/evst_chk.sv
// Checker for evst_irq_regs; attached by bind below.
module evst_chk
    import evst_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [9:0]         evt_in,
    input logic [NUM_EVT-1:0] st_q,
    input logic [NUM_EVT-1:0] mask_q,
    input logic               cd_s,
    input logic               irq,
    input logic               reg_wr_en,
    input logic [1:0]         reg_addr,
    input logic [15:0]        reg_wdata
);
    // R2 R4
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_in) |=> ((st_q[9:0] & $past(evt_in)) == $past(evt_in)));

    // R3
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == 2'd1 && evt_in == '0)
        |=> ((st_q[9:0] & $past(reg_wdata[9:0])) == '0));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == 2'd2) |=> $stable(mask_q));

    // R6
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> ((st_q & mask_q) == '0));

    // R8
    card_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_s != $past(cd_s)) |=> st_q[CHG_BIT]);

    // R2
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && evt_in == '0) |=> ((st_q[9:0] & $past(st_q[9:0])) == $past(st_q[9:0])));
endmodule

bind evst_irq_regs evst_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .st_q(st_q), .mask_q(mask_q),
    .cd_s(cd_s), .irq(irq), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata));

// File: tb/test_evst_irq_regs.sv
module test_evst_irq_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  evt_in = '0;
    logic        card_absent_pin = 1'b1;
    logic        wprot_pin = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;
    string cur_req = "R1";

    evst_irq_regs i_evst_irq_regs (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .card_absent_pin(card_absent_pin), .wprot_pin(wprot_pin),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: pin history held in a queue
    bit   m_st[11];
    bit   m_mask[11];
    bit   cd_hist[$];
    bit   wp_hist[$];
    bit   m_cd_last;

    function automatic int exp_rdata();
        int v = 0;
        if (reg_addr == 0) begin
            for (int i = 0; i < 11; i++) if (m_st[i]) v += (1 << i);
            if (cd_hist[0]) v += (1 << 11);
            if (wp_hist[0]) v += (1 << 12);
        end else if (reg_addr == 2) begin
            for (int i = 0; i < 11; i++) if (m_mask[i]) v += (1 << i);
        end
        return v;
    endfunction

    function automatic bit exp_irq();
        bit r = 0;
        for (int i = 0; i < 11; i++) if (m_st[i] && m_mask[i]) r = 1;
        return r;
    endfunction

    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            for (int i = 0; i < 11; i++) begin m_st[i] = 0; m_mask[i] = 0; end
            cd_hist = {1'b1, 1'b1};
            wp_hist = {1'b0, 1'b0};
            m_cd_last = 1;
        end else begin
            bit chg;
            chg = (cd_hist[0] != m_cd_last);
            m_cd_last = cd_hist[0];
            for (int i = 0; i < 11; i++) begin
                bit setb;
                setb = (i == 10) ? chg : evt_in[i];
                if (reg_wr_en && reg_addr == 1 && reg_wdata[i]) m_st[i] = 0;
                if (setb) m_st[i] = 1;
            end
            if (reg_wr_en && reg_addr == 2)
                for (int i = 0; i < 11; i++) m_mask[i] = reg_wdata[i];
            void'(cd_hist.pop_front()); cd_hist.push_back(card_absent_pin);
            void'(wp_hist.pop_front()); wp_hist.push_back(wprot_pin);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model every cycle, away from the edge
    always @(negedge clk) begin
        if (started && !done) begin
            check({cur_req, " rdata"}, int'(reg_rdata), exp_rdata());
            check({cur_req, " irq"}, int'(irq), int'(exp_irq()));
        end
    end

    task automatic cyc(input logic [9:0] ev, input logic we, input logic [1:0] a, input logic [15:0] d);
        evt_in = ev; reg_wr_en = we; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc('0, 0, reg_addr, '0);
    endtask

    task automatic peek(input string req, input logic [1:0] a, input int exp);
        reg_addr = a; #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1;
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_req = "R1";
        peek("R1 status after reset", 2'd0, 16'h0800);
        peek("R1 mask after reset", 2'd2, 0);
        check("R1 irq after reset", int'(irq), 0);

        cur_req = "R2";
        cyc(10'h005, 0, 0, 0);
        idle(2);
        peek("R2 sticky events", 2'd0, 16'h0805);
        cyc(10'h300, 0, 0, 0);
        cyc(10'h040, 0, 0, 0);
        idle(1);
        peek("R2 more events", 2'd0, 16'h0B45);

        cur_req = "R5";
        cyc('0, 1, 2'd2, 16'hFFFF);
        peek("R5 mask upper bits zero", 2'd2, 16'h07FF);
        cur_req = "R6";
        check("R6 irq with mask", int'(irq), 1);
        cyc('0, 1, 2'd2, 16'h0002);
        check("R6 irq masked out", int'(irq), 0);
        cyc('0, 1, 2'd2, 16'h0100);
        check("R6 irq bit8", int'(irq), 1);

        cur_req = "R3";
        cyc('0, 1, 2'd1, 16'h0101);
        peek("R3 clear selected bits", 2'd0, 16'h0A44);
        check("R3 irq drops", int'(irq), 0);

        cur_req = "R4";
        cyc(10'h004, 1, 2'd1, 16'h0004);
        peek("R4 set wins", 2'd0, 16'h0A44);
        cyc(10'h001, 1, 2'd1, 16'h0001);
        peek("R4 set wins new bit", 2'd0, 16'h0A45);

        cur_req = "R9";
        cyc('0, 1, 2'd0, 16'h0000);
        peek("R9 status write ignored", 2'd0, 16'h0A45);
        cyc('0, 1, 2'd1, 16'h1800);
        peek("R9 clear of level bits ignored", 2'd0, 16'h0A45);
        peek("R9 clear reads zero", 2'd1, 0);
        peek("R9 spare reads zero", 2'd3, 0);

        cur_req = "R7";
        reg_addr = 2'd0;
        card_absent_pin = 1'b0;
        wprot_pin = 1'b1;
        idle(1);
        peek("R7 one edge not yet", 2'd0, 16'h0A45);
        idle(1);
        peek("R7 level after two edges", 2'd0, 16'h1245);
        cur_req = "R8";
        idle(1);
        peek("R8 card change set", 2'd0, 16'h1645);

        cyc('0, 1, 2'd1, 16'h07FF);
        peek("R8 cleared all", 2'd0, 16'h1000);
        cyc('0, 1, 2'd2, 16'h0400);
        card_absent_pin = 1'b1;
        idle(3);
        peek("R8 falling-to-rising change", 2'd0, 16'h1C00);
        check("R8 irq on change", int'(irq), 1);

        cur_req = "R1";
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        peek("R1 reset mid-run", 2'd0, 16'h1800);
        peek("R1 mask cleared", 2'd2, 0);

        done = 1;
        report();
    end
endmodule